// File: doc/BRIEF.md
# Coincidence and Anti-Coincidence Event Qualifier

This block sits between the hit comparators of a pixelated solid-state detector and the readout logic. It watches sixteen position-pixel hit lines, one energy-detector hit line and a small set of veto lines. It decides whether a group of hits forms a valid particle event. Each input can be switched off individually. The first enabled hit opens a coincidence window whose length is set by configuration. At the end of the window the block accepts the event only if the energy detector and at least one position pixel fired, and no enabled veto was seen while the window was open.

An accepted event raises an event flag and freezes the hit pattern until the readout polls the block. A poll strobe releases the flag and pattern onto a shared bus and drives the output-enable; while the strobe is low the bus lines are quiet. When the strobe falls at the end of a poll, the event is cleared. If pile-up rejection is enabled, another enabled pixel hit that arrives before the poll discards the held event. All settings come in through a serial set-up chain and take effect on a load strobe.

Top module: `coinc_qualifier`

## Requirements
- R1: After reset the event flag, the bus output-enable and every bus data bit are 0. The active configuration is all zero, so every input is disabled and no hit can produce an event.
- R2: While cfg_shift is high, each clock shifts cfg_sdi into the MSB of a 26-bit shadow register, which moves toward bit 0. A cfg_load pulse copies the shadow into the active configuration, and shifting alone leaves the active configuration unchanged. The active layout is: bits 15:0 pixel enables, bit 16 energy enable, bits 20:17 veto enables, bits 24:21 window field F, bit 25 pile-up rejection enable.
- R3: A disabled pixel or energy input is ignored. It opens no window and never appears in the pattern.
- R4: The window lasts F+1 clock cycles, counting the cycle of the first enabled hit. Hits sampled on the last of those cycles count toward the event; later hits do not. F=0 gives a single-cycle window.
- R5: When the window closes, the event is accepted only if the energy bit and at least one pixel bit are set. The event flag rises on the clock edge that closes the window.
- R6: Any enabled veto sampled during the window rejects the event. A disabled veto has no effect.
- R7: When pile-up rejection is enabled, an enabled pixel hit while an event is held and not yet polled clears the event on that edge. Disabled pixels do not trigger this.
- R8: bus_oe follows poll. While poll is high, bus_data carries the event flag in bit 17, the energy bit in bit 16 and the pixel pattern in bits 15:0. While poll is low, bus_data is all zero.
- R9: A held event that has been polled is cleared on the first clock edge at which poll is seen low again, and the block is then ready for a new window.
- R10: While an event is held, new hits do not change the latched pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_hit | input | 16 | Position-pixel comparator hits |
| nrg_hit | input | 1 | Energy-detector comparator hit |
| veto_in | input | 4 | Anti-coincidence veto inputs |
| cfg_shift | input | 1 | Shift enable for the set-up chain |
| cfg_sdi | input | 1 | Serial set-up data |
| cfg_load | input | 1 | Copy set-up chain into active configuration |
| poll | input | 1 | Poll strobe releasing the bus |
| evt_flag | output | 1 | Qualified event held |
| bus_oe | output | 1 | Output-enable for the shared bus |
| bus_data | output | 18 | Event flag and latched hit pattern, zero when not polled |

## Verification
A stale window counter moves the rise of evt_flag away from the F+1 edge. That shows up on the first event, on the exact cycle that the bench probes one edge before and one edge after the close. A wrong accumulator or veto record appears as a missing event or a wrong bit in bus_data at the next poll. A stuck polled or hold state appears as evt_flag staying high one edge after poll falls, or as a held event that survives a pile-up hit. A corrupted configuration chain changes which inputs open windows, and this is visible from the first stimulus after the load.

// File: rtl/cq_pkg.sv
package cq_pkg;
    localparam int unsigned NPIX_DEF  = 16;
    localparam int unsigned NVETO_DEF = 4;
    localparam int unsigned WBITS_DEF = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_HOLD = 2'd2
    } qual_state_e;

    // pixel enables, energy enable, veto enables, window field, pile-up enable
    function automatic int unsigned cfg_width(input int unsigned np,
                                              input int unsigned nv,
                                              input int unsigned wb);
        return np + 1 + nv + wb + 1;
    endfunction
endpackage

// File: rtl/cq_cfg_chain.sv
module cq_cfg_chain #(
    parameter int unsigned W = 26
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         sdi,
    input  logic         load,
    output logic [W-1:0] cfg
);
    typedef struct packed {
        logic [W-1:0] sreg;
        logic [W-1:0] act;
    } chain_t;

    chain_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (shift_en) r_d.sreg = {sdi, r_q.sreg[W-1:1]};
        if (load)     r_d.act  = r_q.sreg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg = r_q.act;
endmodule

// File: rtl/cq_window.sv
module cq_window
    import cq_pkg::*;
#(
    parameter int unsigned NPIX  = NPIX_DEF,
    parameter int unsigned NVETO = NVETO_DEF,
    parameter int unsigned WBITS = WBITS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIX-1:0]  pix_hit,
    input  logic             nrg_hit,
    input  logic [NVETO-1:0] veto_in,
    input  logic [NPIX-1:0]  pix_en,
    input  logic             nrg_en,
    input  logic [NVETO-1:0] veto_en,
    input  logic [WBITS-1:0] win_len,
    input  logic             pileup_en,
    input  logic             poll,
    output logic             evt,
    output logic [NPIX:0]    pat
);
    typedef struct packed {
        qual_state_e      st;
        logic [WBITS-1:0] cnt;
        logic [NPIX:0]    acc;
        logic             vetoed;
        logic             polled;
        logic             evt;
        logic [NPIX:0]    pat;
    } win_state_t;

    localparam win_state_t IDLE_ST = '{st: ST_IDLE, cnt: '0, acc: '0,
                                       vetoed: 1'b0, polled: 1'b0,
                                       evt: 1'b0, pat: '0};

    win_state_t    r_q, r_d;
    logic [NPIX:0] hits_m;
    logic [NPIX:0] acc_c;
    logic          veto_m;
    logic          vet_c;
    logic          in_open;
    logic          pass;
    logic          close_now;

    always_comb begin
        hits_m    = {nrg_hit & nrg_en, pix_hit & pix_en};
        veto_m    = |(veto_in & veto_en);
        in_open   = (r_q.st == ST_OPEN);
        acc_c     = (in_open ? r_q.acc : '0) | hits_m;
        vet_c     = (in_open & r_q.vetoed) | veto_m;
        pass      = acc_c[NPIX] & (|acc_c[NPIX-1:0]) & ~vet_c;
        close_now = 1'b0;
        r_d       = r_q;

        unique case (r_q.st)
            ST_IDLE: begin
                if (|hits_m) begin
                    r_d.acc    = acc_c;
                    r_d.vetoed = vet_c;
                    if (win_len == '0) begin
                        close_now = 1'b1;
                    end else begin
                        r_d.st  = ST_OPEN;
                        r_d.cnt = win_len;
                    end
                end
            end
            ST_OPEN: begin
                r_d.acc    = acc_c;
                r_d.vetoed = vet_c;
                r_d.cnt    = r_q.cnt - 1'b1;
                if (r_q.cnt == WBITS'(1)) close_now = 1'b1;
            end
            ST_HOLD: begin
                if (poll) begin
                    r_d.polled = 1'b1;
                end else if (r_q.polled ||
                             (pileup_en && (|hits_m[NPIX-1:0]))) begin
                    r_d = IDLE_ST;
                end
            end
            default: r_d = IDLE_ST;
        endcase

        if (close_now) begin
            if (pass) begin
                r_d.st     = ST_HOLD;
                r_d.evt    = 1'b1;
                r_d.pat    = acc_c;
                r_d.polled = 1'b0;
                r_d.cnt    = '0;
            end else begin
                r_d = IDLE_ST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= IDLE_ST;
        else        r_q <= r_d;
    end

    assign evt = r_q.evt;
    assign pat = r_q.pat;
endmodule

// File: rtl/cq_bus.sv
module cq_bus #(
    parameter int unsigned PATW = 17
) (
    input  logic            poll,
    input  logic            evt,
    input  logic [PATW-1:0] pat,
    output logic            oe,
    output logic [PATW:0]   data
);
    always_comb begin
        oe   = poll;
        data = poll ? {evt, pat} : '0;
    end
endmodule

// File: rtl/coinc_qualifier.sv
module coinc_qualifier
    import cq_pkg::*;
#(
    parameter int unsigned NPIX  = NPIX_DEF,
    parameter int unsigned NVETO = NVETO_DEF,
    parameter int unsigned WBITS = WBITS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPIX-1:0]  pix_hit,
    input  logic             nrg_hit,
    input  logic [NVETO-1:0] veto_in,
    input  logic             cfg_shift,
    input  logic             cfg_sdi,
    input  logic             cfg_load,
    input  logic             poll,
    output logic             evt_flag,
    output logic             bus_oe,
    output logic [NPIX+1:0]  bus_data
);
    localparam int unsigned PATW     = NPIX + 1;
    localparam int unsigned CFGW     = cfg_width(NPIX, NVETO, WBITS);
    localparam int unsigned OFS_NRG  = NPIX;
    localparam int unsigned OFS_VETO = NPIX + 1;
    localparam int unsigned OFS_WIN  = OFS_VETO + NVETO;
    localparam int unsigned OFS_PU   = OFS_WIN + WBITS;

    logic [CFGW-1:0] cfg_q;
    logic [PATW-1:0] pat_q;
    logic            evt_q;

    cq_cfg_chain #(.W(CFGW)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift),
        .sdi      (cfg_sdi),
        .load     (cfg_load),
        .cfg      (cfg_q)
    );

    cq_window #(.NPIX(NPIX), .NVETO(NVETO), .WBITS(WBITS)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_hit   (pix_hit),
        .nrg_hit   (nrg_hit),
        .veto_in   (veto_in),
        .pix_en    (cfg_q[NPIX-1:0]),
        .nrg_en    (cfg_q[OFS_NRG]),
        .veto_en   (cfg_q[OFS_VETO +: NVETO]),
        .win_len   (cfg_q[OFS_WIN +: WBITS]),
        .pileup_en (cfg_q[OFS_PU]),
        .poll      (poll),
        .evt       (evt_q),
        .pat       (pat_q)
    );

    cq_bus #(.PATW(PATW)) u_bus (
        .poll (poll),
        .evt  (evt_q),
        .pat  (pat_q),
        .oe   (bus_oe),
        .data (bus_data)
    );

    assign evt_flag = evt_q;
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
    parameter int unsigned NPIX = 16,
    parameter int unsigned CFGW = 26
) (
    input logic            clk,
    input logic            rst_n,
    input logic            poll,
    input logic            cfg_load,
    input logic            evt_flag,
    input logic            bus_oe,
    input logic [NPIX+1:0] bus_data,
    input logic [NPIX:0]   pat,
    input logic [CFGW-1:0] cfg
);
    // R8: bus quiet when not polled
    p_quiet_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !poll |-> (bus_data == '0));

    // R8: enable released with the poll strobe
    p_oe_poll_r8: assert property (@(posedge clk) disable iff (!rst_n)
        poll |-> bus_oe);

    // R5: held event always has energy and a pixel
    p_evt_rule_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_flag |-> (pat[NPIX] && (|pat[NPIX-1:0])));

    // R10: pattern frozen while the event is held
    p_pattern_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && $past(evt_flag)) |-> $stable(pat));

    // R9: poll end clears the event
    p_poll_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flag && $past(evt_flag) && $past(poll) && !poll) |=> !evt_flag);

    // R2: active configuration changes only on load
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(cfg));
endmodule

bind coinc_qualifier cq_checker #(.NPIX(NPIX), .CFGW(CFGW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .poll     (poll),
    .cfg_load (cfg_load),
    .evt_flag (evt_flag),
    .bus_oe   (bus_oe),
    .bus_data (bus_data),
    .pat      (pat_q),
    .cfg      (cfg_q)
);

// File: tb/sim_coinc_qualifier.sv
`timescale 1ns/1ps
module sim_coinc_qualifier;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pix_hit = '0;
    logic        nrg_hit = 1'b0;
    logic [3:0]  veto_in = '0;
    logic        cfg_shift = 1'b0;
    logic        cfg_sdi = 1'b0;
    logic        cfg_load = 1'b0;
    logic        poll = 1'b0;
    logic        evt_flag;
    logic        bus_oe;
    logic [17:0] bus_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    coinc_qualifier u0 (
        .clk(clk), .rst_n(rst_n), .pix_hit(pix_hit), .nrg_hit(nrg_hit),
        .veto_in(veto_in), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
        .cfg_load(cfg_load), .poll(poll), .evt_flag(evt_flag),
        .bus_oe(bus_oe), .bus_data(bus_data)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [25:0] mk_cfg(input logic [15:0] pe, input logic ne,
                                           input logic [3:0] ve, input logic [3:0] wf,
                                           input logic pu);
        return {pu, wf, ve, ne, pe};
    endfunction

    task automatic shift_bits(input logic [25:0] v);
        for (int i = 0; i < 26; i++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_sdi   = v[i];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_sdi   = 1'b0;
    endtask

    task automatic load_cfg(input logic [25:0] v);
        shift_bits(v);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic step(input logic [15:0] p, input logic n, input logic [3:0] v);
        @(negedge clk);
        pix_hit = p;
        nrg_hit = n;
        veto_in = v;
    endtask

    task automatic idle(input int k);
        repeat (k) step('0, 1'b0, '0);
    endtask

    task automatic poll_read(output logic [17:0] d, output logic oe);
        @(negedge clk);
        poll = 1'b1;
        #1;
        d  = bus_data;
        oe = bus_oe;
        @(negedge clk);
        poll = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [17:0] d;
        logic        oe;
        check("R1 evt after reset", 32'(evt_flag), 32'd0);
        check("R1 oe after reset", 32'(bus_oe), 32'd0);
        check("R1 data after reset", 32'(bus_data), 32'd0);
        step(16'hFFFF, 1'b1, '0);
        idle(6);
        check("R1 R3 no event with reset config", 32'(evt_flag), 32'd0);
        poll_read(d, oe);
        check("R8 oe during poll", 32'(oe), 32'd1);
        check("R8 data with no event", 32'(d), 32'd0);
    endtask

    task automatic t_basic;
        logic [17:0] d;
        logic        oe;
        load_cfg(mk_cfg(16'hFFFF, 1'b1, 4'hF, 4'd3, 1'b0));
        step(16'h0020, 1'b1, '0);
        idle(2);
        step(16'h0200, 1'b0, '0);
        check("R4 flag low before window close", 32'(evt_flag), 32'd0);
        step(16'h1000, 1'b0, '0);
        check("R5 flag on closing edge", 32'(evt_flag), 32'd1);
        idle(1);
        check("R8 bus quiet while held", 32'(bus_data), 32'd0);
        poll_read(d, oe);
        check("R4 R10 polled pattern", 32'(d), 32'h30220);
        check("R9 cleared after poll", 32'(evt_flag), 32'd0);
        check("R8 oe dropped", 32'(bus_oe), 32'd0);
    endtask

    task automatic t_window_edge;
        logic [17:0] d;
        logic        oe;
        load_cfg(mk_cfg(16'hFFFF, 1'b1, 4'hF, 4'd2, 1'b0));
        step(16'h0008, 1'b0, '0);
        idle(2);
        step('0, 1'b1, '0);
        idle(6);
        check("R4 energy after window ignored", 32'(evt_flag), 32'd0);
        step(16'h0008, 1'b0, '0);
        idle(1);
        step('0, 1'b1, '0);
        step('0, 1'b0, '0);
        check("R4 energy in last window cycle", 32'(evt_flag), 32'd1);
        poll_read(d, oe);
        check("R4 edge pattern", 32'(d), 32'h30008);
        load_cfg(mk_cfg(16'hFFFF, 1'b1, 4'hF, 4'd0, 1'b0));
        step(16'h0080, 1'b1, '0);
        step('0, 1'b0, '0);
        check("R4 single-cycle window", 32'(evt_flag), 32'd1);
        poll_read(d, oe);
        check("R4 single-cycle pattern", 32'(d), 32'h30080);
    endtask

    task automatic t_mask;
        logic [17:0] d;
        logic        oe;
        load_cfg(mk_cfg(16'h00FF, 1'b1, 4'h0, 4'd1, 1'b0));
        step(16'h0404, 1'b1, '0);
        step('0, 1'b0, '0);
        step('0, 1'b0, '0);
        check("R3 event with masked pixel", 32'(evt_flag), 32'd1);
        poll_read(d, oe);
        check("R3 masked pixel absent", 32'(d), 32'h30004);
        load_cfg(mk_cfg(16'h00FF, 1'b0, 4'h0, 4'd1, 1'b0));
        step(16'h0004, 1'b1, '0);
        idle(5);
        check("R3 disabled energy input", 32'(evt_flag), 32'd0);
    endtask

    task automatic t_veto;
        logic [17:0] d;
        logic        oe;
        load_cfg(mk_cfg(16'hFFFF, 1'b1, 4'b0010, 4'd3, 1'b0));
        step(16'h0002, 1'b1, '0);
        step('0, 1'b0, 4'b0010);
        idle(3);
        check("R6 enabled veto rejects", 32'(evt_flag), 32'd0);
        idle(2);
        check("R6 stays rejected", 32'(evt_flag), 32'd0);
        step(16'h0002, 1'b1, '0);
        step('0, 1'b0, 4'b0001);
        idle(3);
        check("R6 disabled veto ignored", 32'(evt_flag), 32'd1);
        poll_read(d, oe);
        check("R6 pattern after ignored veto", 32'(d), 32'h30002);
    endtask

    task automatic t_pileup;
        load_cfg(mk_cfg(16'h00FF, 1'b1, 4'h0, 4'd1, 1'b1));
        step(16'h0001, 1'b1, '0);
        step('0, 1'b0, '0);
        step(16'h1000, 1'b0, '0);
        check("R7 event held", 32'(evt_flag), 32'd1);
        step('0, 1'b0, '0);
        check("R7 disabled pixel no pile-up", 32'(evt_flag), 32'd1);
        step(16'h0008, 1'b0, '0);
        check("R7 still held before hit", 32'(evt_flag), 32'd1);
        step('0, 1'b0, '0);
        check("R7 pile-up discards event", 32'(evt_flag), 32'd0);
        idle(2);
    endtask

    task automatic t_noload;
        logic [17:0] d;
        logic        oe;
        load_cfg(mk_cfg(16'hFFFF, 1'b1, 4'h0, 4'd0, 1'b0));
        shift_bits('0);
        step(16'h4000, 1'b1, '0);
        step('0, 1'b0, '0);
        check("R2 shift without load keeps config", 32'(evt_flag), 32'd1);
        poll_read(d, oe);
        check("R2 pattern under kept config", 32'(d), 32'h34000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_window_edge();
        t_mask();
        t_veto();
        t_pileup();
        t_noload();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule